// File: doc/BRIEF.md
# Serial DAC Word Receiver

This block is the digital front end of a 16-bit serial-input digital-to-analog converter. A host frames each transfer with an active-low chip select and clocks data in, most significant bit first, on the rising edge of a serial clock. All three serial inputs and the active-low load strobe are resynchronised into the system clock domain. The serial clock is then treated as a sampled signal whose rising edges are detected. Bits move through an input shift register. A holding register, which drives the converter, takes a copy of the shift register at defined moments.

There are two ways to load the holding register. If the load strobe is held low, the rising edge of chip select copies the word directly. If the strobe is held high during shifting, the word waits after chip select rises and is copied when the strobe is pulled low. A controller with three states sequences these loads. ST_IDLE means deselected with nothing pending. ST_SHIFT means a frame is in progress. ST_ARMED means a frame has ended and is waiting for the strobe. The transitions are:
- ST_IDLE to ST_SHIFT on the falling edge of chip select.
- ST_SHIFT to ST_IDLE on the rising edge of chip select with the strobe low (a load).
- ST_SHIFT to ST_ARMED on the rising edge of chip select with the strobe high.
- ST_ARMED to ST_IDLE on a falling edge of the strobe while deselected (a load).
- ST_ARMED to ST_SHIFT on the falling edge of chip select.

A falling edge of the strobe in ST_IDLE while deselected also reloads the holding register.

Frames of the wrong length are not rejected. The shift register simply keeps shifting, so a long frame keeps its last 16 bits and a short frame keeps older bits in its upper positions. A saturating bit counter reports short frames. Reset clears the holding register and leaves the shift register untouched.

Top module: `sdac_frontend`

## Requirements
- R1: Serial data is taken only on a rising edge of the serial clock while chip select (`cs_n`) is low. Clock edges while `cs_n` is high leave the shift register unchanged.
- R2: Bits enter most significant bit first. After a frame of exactly 16 bits and a load, `dac_word` equals the 16 bits in the order they were sent.
- R3: If a frame has more than 16 bits, a load gives the last 16 bits shifted in.
- R4: If a frame has n < 16 bits, a load gives {previous shift contents[15-n:0], new n bits}.
- R5: If `ldac_n` is low when `cs_n` rises, the shift register is copied into `dac_word`.
- R6: If `ldac_n` is high when `cs_n` rises, `dac_word` is unchanged. A later falling edge of `ldac_n` while `cs_n` is high copies the shift register.
- R7: A falling edge of `ldac_n` while `cs_n` is low causes no load.
- R8: Reset drives `dac_word` to 0 and `upd_pulse` and `short_frame` to 0. The shift register keeps its contents through reset.
- R9: `upd_pulse` is high for exactly one clock cycle per load, and `dac_word` never changes without it.
- R10: On each rising edge of `cs_n` that ends a frame, `short_frame` is set to 1 if fewer than 16 bits were clocked in that frame, and to 0 otherwise. It changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_n | input | 1 | Active-low chip select that frames a word |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi | input | 1 | Serial data, most significant bit first |
| ldac_n | input | 1 | Active-low load strobe |
| dac_word | output | 16 | Holding register value that drives the converter |
| upd_pulse | output | 1 | One-cycle pulse on each load of `dac_word` |
| short_frame | output | 1 | Set when the last frame had fewer than 16 bits |

## Verification
The bench sends frames of 20 bits and of 4 bits. If a design dropped the surplus bits instead of the leading bits, the long frame would load the wrong word. If it cleared or zero-filled the register, the short frame would lose the carried-over bits.

The bench toggles the serial clock while chip select is high, then loads the register with a frame of zero length. A design that did not gate sampling with chip select would return a shifted word.

The bench pulses the strobe low in the middle of a frame, and it also holds the strobe high across the rising edge of chip select. A design that ignored the load mode would update early in either case.

Reset is applied between a full frame and a short frame. A design that cleared the shift register on reset would show zeros where the earlier bits should carry over. Random frames with random lengths and load modes are checked against a bit-level model.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_ARMED = 2'd2
    } ctrl_state_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
    parameter int W     = 16,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    input  logic         frame_start,
    output logic [W-1:0] word,
    output logic         frame_short
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(W);

    logic [W-1:0]     sreg;
    logic [CNT_W-1:0] cnt;

    // Input register is deliberately left out of reset.
    always_ff @(posedge clk) begin
        if (shift_en) sreg <= {sreg[W-2:0], bit_in};
    end

    // Saturating bit counter; only feeds the short-frame flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (frame_start) begin
            cnt <= shift_en ? CNT_W'(1) : '0;
        end else if (shift_en && cnt != CNT_MAX) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign word        = sreg;
    assign frame_short = (cnt < CNT_MAX);
endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
    import sdac_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_fall,
    input  logic         cs_rise,
    input  logic         cs_high,
    input  logic         ldac_fall,
    input  logic         ldac_low,
    input  logic [W-1:0] word_in,
    input  logic         frame_short,
    output logic [W-1:0] dac_word,
    output logic         upd_pulse,
    output logic         short_flag
);
    ctrl_state_e state_q, state_d;
    logic        load;

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_fall) begin
                    state_d = ST_SHIFT;
                end else if (ldac_fall && cs_high) begin
                    load = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (cs_rise) begin
                    if (ldac_low) begin
                        load    = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_ARMED;
                    end
                end
            end
            ST_ARMED: begin
                if (cs_fall) begin
                    state_d = ST_SHIFT;
                end else if (ldac_fall && cs_high) begin
                    load    = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_word   <= '0;
            upd_pulse  <= 1'b0;
            short_flag <= 1'b0;
        end else begin
            upd_pulse <= load;
            if (load) dac_word <= word_in;
            if (state_q == ST_SHIFT && cs_rise) short_flag <= frame_short;
        end
    end
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend #(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              ldac_n,
    output logic [WORD_W-1:0] dac_word,
    output logic              upd_pulse,
    output logic              short_frame
);
    localparam int NSIG = 4;
    // bit order: {ldac_n, sdi, sclk, cs_n}; idle = deselected, strobe low
    localparam logic [NSIG-1:0] SYNC_RST = 4'b0001;

    logic [NSIG-1:0] raw_in, sync_out;
    logic cs_hi_s, sclk_s, sdi_s, ldac_s;
    logic cs_q, sclk_q, ldac_q;
    logic cs_rise, cs_fall, sclk_rise, ldac_fall;
    logic [WORD_W-1:0] in_word;
    logic in_short;

    assign raw_in = {ldac_n, sdi, sclk, cs_n};

    sdac_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_out)
    );

    assign {ldac_s, sdi_s, sclk_s, cs_hi_s} = sync_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
            ldac_q <= 1'b0;
        end else begin
            cs_q   <= cs_hi_s;
            sclk_q <= sclk_s;
            ldac_q <= ldac_s;
        end
    end

    assign cs_rise   =  cs_hi_s & ~cs_q;
    assign cs_fall   = ~cs_hi_s &  cs_q;
    assign sclk_rise =  sclk_s  & ~sclk_q & ~cs_hi_s;
    assign ldac_fall = ~ldac_s  &  ldac_q;

    sdac_shifter #(.W(WORD_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_en    (sclk_rise),
        .bit_in      (sdi_s),
        .frame_start (cs_fall),
        .word        (in_word),
        .frame_short (in_short)
    );

    sdac_ctrl #(.W(WORD_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_fall     (cs_fall),
        .cs_rise     (cs_rise),
        .cs_high     (cs_hi_s),
        .ldac_fall   (ldac_fall),
        .ldac_low    (~ldac_s),
        .word_in     (in_word),
        .frame_short (in_short),
        .dac_word    (dac_word),
        .upd_pulse   (upd_pulse),
        .short_flag  (short_frame)
    );
endmodule

// File: rtl/sdac_frontend_chk.sv
module sdac_frontend_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_hi_s,
    input logic              cs_rise,
    input logic [WORD_W-1:0] dac_word,
    input logic              upd_pulse,
    input logic              short_frame
);
    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (dac_word == '0 && !upd_pulse && !short_frame));

    a_r9_change_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_word != $past(dac_word)) |-> upd_pulse);

    a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |=> !upd_pulse);

    a_r7_load_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> $past(cs_hi_s));

    a_r10_flag_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(short_frame) |-> $past(cs_rise));
endmodule

bind sdac_frontend sdac_frontend_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_hi_s     (cs_hi_s),
    .cs_rise     (cs_rise),
    .dac_word    (dac_word),
    .upd_pulse   (upd_pulse),
    .short_frame (short_frame)
);

// File: tb/sdac_frontend_bench.sv
module sdac_frontend_bench;
    logic clk = 1'b0;
    logic rst_n, cs_n, sclk, sdi, ldac_n;
    logic [15:0] dac_word;
    logic upd_pulse, short_frame;

    int checks = 0, errors = 0;
    int pulses = 0, exp_pulses = 0, wide = 0;
    logic prev_upd = 1'b0;
    bit done = 1'b0;

    logic [15:0] m_sreg, m_dac;
    logic        m_short;

    always #2 clk = ~clk;  // 250 MHz

    sdac_frontend u_sdac_frontend (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .ldac_n(ldac_n), .dac_word(dac_word), .upd_pulse(upd_pulse),
        .short_frame(short_frame)
    );

    always @(negedge clk) begin
        if (upd_pulse) pulses++;
        if (upd_pulse && prev_upd) wide++;
        prev_upd = upd_pulse;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] shift_in(input logic [15:0] s, input logic b);
        return {s[14:0], b};
    endfunction

    task automatic set_ldac(input logic v);
        if (ldac_n === 1'b1 && v == 1'b0 && cs_n == 1'b1) begin
            m_dac = m_sreg;
            exp_pulses++;
        end
        ldac_n = v;
        wait_clk(8);
    endtask

    task automatic send_frame(input logic [31:0] val, input int n);
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = val[i];
            wait_clk(3);
            sclk = 1'b1;
            m_sreg = shift_in(m_sreg, val[i]);
            wait_clk(3);
            sclk = 1'b0;
        end
        wait_clk(3);
        cs_n = 1'b1;
        m_short = (n < 16);
        if (ldac_n == 1'b0) begin
            m_dac = m_sreg;
            exp_pulses++;
        end
        wait_clk(8);
    endtask

    task automatic check_all(input string tag);
        chk({tag, " word"}, {16'h0, dac_word}, {16'h0, m_dac});
        chk({tag, " pulses"}, pulses, exp_pulses);
        chk({tag, " short"}, {31'h0, short_frame}, {31'h0, m_short});
    endtask

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0; ldac_n = 1'b0;
        m_sreg = '0; m_dac = '0; m_short = 1'b0;
        void'($urandom(32'd1234));
        wait_clk(5);
        check_all("R8 reset state");
        rst_n = 1'b1;
        wait_clk(4);

        // R2 R5 R10: full word, strobe tied low
        send_frame(32'hA5C3, 16);
        check_all("R2 R5 full frame");
        // R3: long frame keeps last 16 bits
        send_frame(32'hF1234, 20);
        chk("R3 long frame", {16'h0, dac_word}, 32'h1234);
        check_all("R3 long frame");
        // R4 R10: short frame carries old bits
        send_frame(32'hB, 4);
        chk("R4 short frame", {16'h0, dac_word}, 32'h234B);
        check_all("R4 short frame");
        // R1: clocks while deselected are ignored; zero-bit frame reloads
        for (int i = 0; i < 5; i++) begin
            sdi = 1'($urandom);
            wait_clk(3); sclk = 1'b1; wait_clk(3); sclk = 1'b0;
        end
        send_frame(32'h0, 0);
        chk("R1 deselected clocks", {16'h0, dac_word}, 32'h234B);
        check_all("R1 deselected clocks");
        // R6: strobe high during frame, load on later falling edge
        set_ldac(1'b1);
        send_frame(32'h5A5A, 16);
        chk("R6 held off", {16'h0, dac_word}, 32'h234B);
        check_all("R6 held off");
        set_ldac(1'b0);
        chk("R6 strobe load", {16'h0, dac_word}, 32'h5A5A);
        check_all("R6 strobe load");
        // R7: strobe pulse while selected is ignored
        set_ldac(1'b1);
        send_frame(32'h1111, 16);
        cs_n = 1'b0; wait_clk(4);
        ldac_n = 1'b0; wait_clk(8);
        ldac_n = 1'b1; wait_clk(8);
        cs_n = 1'b1; m_short = 1'b1; wait_clk(8);
        chk("R7 strobe while selected", {16'h0, dac_word}, 32'h5A5A);
        check_all("R7 strobe while selected");
        set_ldac(1'b0);
        check_all("R7 later load");
        // R8: reset clears holding register, not shift register
        send_frame(32'hC0DE, 16);
        check_all("R8 pre-reset");
        rst_n = 1'b0; wait_clk(4);
        m_dac = '0; m_short = 1'b0;
        check_all("R8 mid reset");
        rst_n = 1'b1; wait_clk(4);
        send_frame(32'h7, 4);
        chk("R8 retention", {16'h0, dac_word}, 32'h0DE7);
        check_all("R8 retention");

        // random frames, mixed modes
        for (int k = 0; k < 40; k++) begin
            int len = $urandom_range(24, 1);
            logic [31:0] val = $urandom;
            if ($urandom_range(1, 0) == 0) begin
                set_ldac(1'b0);
                send_frame(val, len);
                check_all("R3 R4 R5 R10 random cs load");
            end else begin
                set_ldac(1'b1);
                send_frame(val, len);
                check_all("R6 random held");
                set_ldac(1'b0);
                check_all("R6 random strobe load");
            end
        end

        chk("R9 pulse width", wide, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule